// File: doc/BRIEF.md
# Segment Limit and Bounds Checker

This block takes the packed limit attributes of a segment (a 20-bit raw limit, a granularity flag, a grow-downward flag and a wide-top flag) and turns them into a byte-granular 32-bit limit. It then decides whether one memory access falls wholly inside the segment. An access is given as a starting offset and a size code for 1, 2 or 4 bytes. The check computes the address of the last byte touched and compares it against the segment's valid range. Any byte outside the range, or a carry past the top of the address space, produces a fault.

A second mode checks a descriptor-table index instead of an access. Each table entry is eight bytes long, and the limit marks the last valid byte of the table. An index passes only when the final byte of its entry does not go beyond that limit.

Every request produces one registered response a cycle later. The response carries a fault flag and the expanded limit, so the same block can answer a plain "what is the byte limit" query.

Top module: `seg_bound_check`

## Requirements
- R1: With `req_gran` low, `rsp_limit` equals `req_limit_raw` zero-extended to 32 bits.
- R2: With `req_gran` high, `rsp_limit` equals `req_limit_raw` shifted left by 12 with the low 12 bits set to one.
- R3: In segment mode (`req_table`=0) with `req_expand_down`=0, an access faults exactly when its last byte (offset + size − 1) exceeds the expanded limit. The size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R4: A segment-mode access whose last byte would carry past 0xFFFFFFFF faults, even when the limit is 0xFFFFFFFF.
- R5: In segment mode with `req_expand_down`=1, an access faults when its offset is less than or equal to the expanded limit.
- R6: In segment mode with `req_expand_down`=1, the top of the valid range is 0xFFFF when `req_big`=0 and 0xFFFFFFFF when `req_big`=1. An access whose last byte lies above that top faults.
- R7: A grow-downward segment with a raw limit of zero and granularity clear accepts every offset from 1 up to its top.
- R8: In table mode (`req_table`=1), the request faults exactly when index×8+7 exceeds the expanded limit. In this mode `req_offset`, `req_size`, `req_expand_down` and `req_big` have no effect.
- R9: In segment mode, size code 3 is reserved and always faults.
- R10: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. `rsp_fault` and `rsp_limit` hold their values while no request arrives.
- R11: While `rst_n` is low, `rsp_valid`, `rsp_fault` and `rsp_limit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_table | input | 1 | 1 = table-index check, 0 = segment access check |
| req_limit_raw | input | 20 | Raw limit field |
| req_gran | input | 1 | Granularity: 1 = 4 KiB units with low ones filled |
| req_expand_down | input | 1 | Segment grows downward (valid range above the limit) |
| req_big | input | 1 | Top of grow-downward range: 0 = 0xFFFF, 1 = 0xFFFFFFFF |
| req_offset | input | 32 | Offset of the first byte accessed |
| req_size | input | 2 | Access size code: 0 = 1, 1 = 2, 2 = 4 bytes, 3 = reserved |
| req_index | input | 13 | Table entry index (table mode) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | 1 = access or index out of bounds |
| rsp_limit | output | 32 | Expanded byte-granular limit |

## Verification
All state in the block is the one response register. A wrong internal value therefore shows up in the very next cycle as a wrong `rsp_fault` or `rsp_limit` beside a valid strobe, or as a strobe that appears or vanishes out of step with `req_valid`. The boundary vectors place accesses one byte inside and one byte outside each edge of the range: the limit itself, limit+1, the 0xFFFF and 0xFFFFFFFF tops, and the last table entry. An off-by-one in the last-byte sum, a lost carry or a swapped top flips the fault bit on the matching vector. Hold behaviour is checked by dropping `req_valid` while changing every input and confirming that the outputs do not move.

// File: rtl/seg_chk_pkg.sv
`timescale 1ns/1ps
package seg_chk_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_RSVD  = 2'd3
   } acc_size_e;

   typedef enum logic {
      CHK_SEG   = 1'b0,
      CHK_TABLE = 1'b1
   } chk_mode_e;
endpackage

// File: rtl/seg_lim_expand.sv
`timescale 1ns/1ps
module seg_lim_expand #(
   parameter int LIMIT_W    = 20,
   parameter int ADDR_W     = 32,
   parameter int GRAN_SHIFT = 12
) (
   input  logic [LIMIT_W-1:0] raw,
   input  logic               gran,
   output logic [ADDR_W-1:0]  lim
);
   localparam int GRAN_W = LIMIT_W + GRAN_SHIFT;

   generate
      if (GRAN_W > ADDR_W) begin : g_bad_width
         $error("seg_lim_expand: LIMIT_W+GRAN_SHIFT exceeds ADDR_W");
      end
      if (GRAN_SHIFT == 0) begin : g_no_gran
         // No granular scaling: the flag cannot change the limit.
         logic unused_gran;
         assign unused_gran = gran;
         assign lim = ADDR_W'(raw);
      end else begin : g_gran
         logic [GRAN_W-1:0] scaled;
         assign scaled = {raw, {GRAN_SHIFT{1'b1}}};
         assign lim    = gran ? ADDR_W'(scaled) : ADDR_W'(raw);
      end
   endgenerate
endmodule

// File: rtl/seg_span_calc.sv
`timescale 1ns/1ps
module seg_span_calc
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] offset,
   input  acc_size_e         size,
   output logic [ADDR_W:0]   last,      // one extra bit keeps the carry
   output logic              size_bad
);
   logic [2:0] len_m1;

   always_comb begin
      size_bad = 1'b0;
      unique case (size)
         SZ_BYTE:  len_m1 = 3'd0;
         SZ_WORD:  len_m1 = 3'd1;
         SZ_DWORD: len_m1 = 3'd3;
         default: begin
            len_m1   = 3'd0;
            size_bad = 1'b1;
         end
      endcase
   end

   assign last = {1'b0, offset} + {{(ADDR_W-2){1'b0}}, len_m1};
endmodule

// File: rtl/seg_bound_cmp.sv
`timescale 1ns/1ps
module seg_bound_cmp
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SMALL_TOP_W = 16,
   parameter int IDX_W       = 13,
   parameter int ENTRY_LOG2  = 3
) (
   input  chk_mode_e         mode,
   input  logic [ADDR_W-1:0] lim,
   input  logic              expand_down,
   input  logic              big,
   input  logic [ADDR_W-1:0] offset,
   input  logic [ADDR_W:0]   last,
   input  logic              size_bad,
   input  logic [IDX_W-1:0]  index,
   output logic              fault
);
   localparam int TBL_W = IDX_W + ENTRY_LOG2;
   localparam logic [ADDR_W:0] TOP_SMALL = (ADDR_W+1)'({SMALL_TOP_W{1'b1}});
   localparam logic [ADDR_W:0] TOP_BIG   = {1'b0, {ADDR_W{1'b1}}};

   logic [ADDR_W:0] lim_x;
   logic [ADDR_W:0] top;
   logic [ADDR_W:0] tbl_last;
   logic            up_fault;
   logic            down_fault;
   logic            tbl_fault;

   assign lim_x = {1'b0, lim};
   assign top   = big ? TOP_BIG : TOP_SMALL;

   generate
      if (ENTRY_LOG2 == 0) begin : g_byte_entry
         assign tbl_last = (ADDR_W+1)'(index);
      end else begin : g_wide_entry
         logic [TBL_W-1:0] ent_end;
         assign ent_end  = {index, {ENTRY_LOG2{1'b1}}};
         assign tbl_last = (ADDR_W+1)'(ent_end);
      end
   endgenerate

   assign up_fault   = last > lim_x;
   assign down_fault = ({1'b0, offset} <= lim_x) || (last > top);
   assign tbl_fault  = tbl_last > lim_x;

   always_comb begin
      if (mode == CHK_TABLE)
         fault = tbl_fault;
      else if (size_bad)
         fault = 1'b1;
      else if (expand_down)
         fault = down_fault;
      else
         fault = up_fault;
   end
endmodule

// File: rtl/seg_bound_check.sv
`timescale 1ns/1ps
module seg_bound_check
   import seg_chk_pkg::*;
#(
   parameter int LIMIT_W     = 20,
   parameter int ADDR_W      = 32,
   parameter int GRAN_SHIFT  = 12,
   parameter int SMALL_TOP_W = 16,
   parameter int IDX_W       = 13,
   parameter int ENTRY_LOG2  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_table,
   input  logic [LIMIT_W-1:0] req_limit_raw,
   input  logic               req_gran,
   input  logic               req_expand_down,
   input  logic               req_big,
   input  logic [ADDR_W-1:0]  req_offset,
   input  logic [1:0]         req_size,
   input  logic [IDX_W-1:0]   req_index,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [ADDR_W-1:0]  rsp_limit
);
   generate
      if (ADDR_W <= LIMIT_W) begin : g_chk_addr
         $error("seg_bound_check: ADDR_W must exceed LIMIT_W");
      end
      if (SMALL_TOP_W >= ADDR_W || SMALL_TOP_W < 1) begin : g_chk_top
         $error("seg_bound_check: SMALL_TOP_W out of range");
      end
      if (IDX_W + ENTRY_LOG2 > ADDR_W) begin : g_chk_tbl
         $error("seg_bound_check: table span exceeds ADDR_W");
      end
      if (ADDR_W < 3) begin : g_chk_min
         $error("seg_bound_check: ADDR_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] lim;
   logic [ADDR_W:0]   last;
   logic              size_bad;
   logic              fault_d;
   chk_mode_e         mode;
   acc_size_e         size;

   assign mode = chk_mode_e'(req_table);
   assign size = acc_size_e'(req_size);

   seg_lim_expand #(
      .LIMIT_W   (LIMIT_W),
      .ADDR_W    (ADDR_W),
      .GRAN_SHIFT(GRAN_SHIFT)
   ) u_expand (
      .raw (req_limit_raw),
      .gran(req_gran),
      .lim (lim)
   );

   seg_span_calc #(
      .ADDR_W(ADDR_W)
   ) u_span (
      .offset  (req_offset),
      .size    (size),
      .last    (last),
      .size_bad(size_bad)
   );

   seg_bound_cmp #(
      .ADDR_W     (ADDR_W),
      .SMALL_TOP_W(SMALL_TOP_W),
      .IDX_W      (IDX_W),
      .ENTRY_LOG2 (ENTRY_LOG2)
   ) u_cmp (
      .mode       (mode),
      .lim        (lim),
      .expand_down(req_expand_down),
      .big        (req_big),
      .offset     (req_offset),
      .last       (last),
      .size_bad   (size_bad),
      .index      (req_index),
      .fault      (fault_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_limit <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= fault_d;
            rsp_limit <= lim;
         end
      end
   end

   // R10: strobe follows request by one cycle
   a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R10: outputs hold while idle
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_fault) && $stable(rsp_limit)));
   // R1: upper bits clear without granularity
   a_r1_plain_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_gran) |=> (rsp_limit[ADDR_W-1:LIMIT_W] == '0));
   generate
      if (GRAN_SHIFT > 0) begin : g_gran_assert
         // R2: granular limit ends in ones
         a_r2_gran_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_gran) |=> (&rsp_limit[GRAN_SHIFT-1:0]));
      end
   endgenerate
   // R3: first byte of a grow-upward segment is always inside
   a_r3_first_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_table && !req_expand_down && req_size == 2'd0
       && req_offset == '0) |=> !rsp_fault);
   // R4: multi-byte access at the very top carries out and faults
   a_r4_carry_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_table && req_size != 2'd0 && (&req_offset))
      |=> rsp_fault);
   // R5: offset zero never lies above the limit of a grow-downward segment
   a_r5_down_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_table && req_expand_down && req_offset == '0)
      |=> rsp_fault);
   // R6: small top bounds grow-downward segments
   a_r6_small_top: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_table && req_expand_down && !req_big
       && req_offset[ADDR_W-1:SMALL_TOP_W] != '0) |=> rsp_fault);
   // R8: entry zero fits any table whose limit covers one entry
   a_r8_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_table && req_index == '0
       && ADDR_W'(req_limit_raw) >= ADDR_W'((1 << ENTRY_LOG2) - 1)) |=> !rsp_fault);
   // R9: reserved size code
   a_r9_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_table && req_size == 2'd3) |=> rsp_fault);
endmodule

// File: tb/seg_bound_check_bench.sv
`timescale 1ns/1ps
module seg_bound_check_bench;
   typedef struct packed {
      logic        tbl;
      logic [19:0] raw;
      logic        g;
      logic        e;
      logic        b;
      logic [31:0] off;
      logic [1:0]  sz;
      logic [12:0] idx;
      logic        flt;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 20'h00FFF, 1'b0, 1'b0, 1'b0, 32'h0000_0FFF, 2'd0, 13'd0, 1'b0, 4'd1}, // R1 R3
      '{1'b0, 20'h00FFF, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 2'd0, 13'd0, 1'b1, 4'd3}, // R3
      '{1'b0, 20'h00FFF, 1'b0, 1'b0, 1'b0, 32'h0000_0FFE, 2'd1, 13'd0, 1'b0, 4'd3}, // R3
      '{1'b0, 20'h00FFF, 1'b0, 1'b0, 1'b0, 32'h0000_0FFF, 2'd1, 13'd0, 1'b1, 4'd3}, // R3
      '{1'b0, 20'h00FFF, 1'b0, 1'b0, 1'b0, 32'h0000_0FFC, 2'd2, 13'd0, 1'b0, 4'd3}, // R3
      '{1'b0, 20'h00FFF, 1'b0, 1'b0, 1'b0, 32'h0000_0FFD, 2'd2, 13'd0, 1'b1, 4'd3}, // R3
      '{1'b0, 20'h00000, 1'b1, 1'b0, 1'b0, 32'h0000_0FFF, 2'd0, 13'd0, 1'b0, 4'd2}, // R2
      '{1'b0, 20'h00000, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 2'd0, 13'd0, 1'b1, 4'd2}, // R2
      '{1'b0, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 2'd2, 13'd0, 1'b0, 4'd4}, // R4
      '{1'b0, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 2'd1, 13'd0, 1'b1, 4'd4}, // R4
      '{1'b0, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFE, 2'd1, 13'd0, 1'b0, 4'd4}, // R4
      '{1'b0, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 2'd0, 13'd0, 1'b0, 4'd4}, // R4
      '{1'b0, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0000_0FFF, 2'd0, 13'd0, 1'b1, 4'd5}, // R5
      '{1'b0, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 2'd0, 13'd0, 1'b0, 4'd5}, // R5
      '{1'b0, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0000_FFFE, 2'd1, 13'd0, 1'b0, 4'd6}, // R6
      '{1'b0, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0000_FFFF, 2'd1, 13'd0, 1'b1, 4'd6}, // R6
      '{1'b0, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0001_0000, 2'd0, 13'd0, 1'b1, 4'd6}, // R6
      '{1'b0, 20'h0FFFF, 1'b0, 1'b1, 1'b1, 32'h0001_0000, 2'd2, 13'd0, 1'b0, 4'd6}, // R6
      '{1'b0, 20'h0FFFF, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFC, 2'd2, 13'd0, 1'b0, 4'd6}, // R6
      '{1'b0, 20'h0FFFF, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFD, 2'd2, 13'd0, 1'b1, 4'd6}, // R6
      '{1'b0, 20'h00000, 1'b0, 1'b1, 1'b1, 32'h0000_0001, 2'd0, 13'd0, 1'b0, 4'd7}, // R7
      '{1'b0, 20'h00000, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 2'd0, 13'd0, 1'b1, 4'd7}, // R7
      '{1'b0, 20'h00000, 1'b0, 1'b1, 1'b0, 32'h0000_FFFC, 2'd2, 13'd0, 1'b0, 4'd7}, // R7
      '{1'b0, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd3, 13'd0, 1'b1, 4'd9}, // R9
      '{1'b1, 20'h00017, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 13'd2, 1'b0, 4'd8}, // R8
      '{1'b1, 20'h00017, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 13'd3, 1'b1, 4'd8}, // R8
      '{1'b1, 20'h00017, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 2'd3, 13'd0, 1'b0, 4'd8}, // R8 ignored fields
      '{1'b1, 20'h00006, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 13'd0, 1'b1, 4'd8}, // R8
      '{1'b1, 20'h00000, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 13'd511, 1'b0, 4'd8}, // R8
      '{1'b1, 20'h00000, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 13'd512, 1'b1, 4'd8}  // R8
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_table;
   logic [19:0] req_limit_raw;
   logic        req_gran;
   logic        req_expand_down;
   logic        req_big;
   logic [31:0] req_offset;
   logic [1:0]  req_size;
   logic [12:0] req_index;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [31:0] rsp_limit;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   seg_bound_check u_seg_bound_check (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_table      (req_table),
      .req_limit_raw  (req_limit_raw),
      .req_gran       (req_gran),
      .req_expand_down(req_expand_down),
      .req_big        (req_big),
      .req_offset     (req_offset),
      .req_size       (req_size),
      .req_index      (req_index),
      .rsp_valid      (rsp_valid),
      .rsp_fault      (rsp_fault),
      .rsp_limit      (rsp_limit)
   );

   function automatic logic [31:0] want_limit(logic [19:0] raw, logic g);
      return g ? {raw, 12'hFFF} : {12'h000, raw};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(vec_t v, logic vld);
      req_valid       = vld;
      req_table       = v.tbl;
      req_limit_raw   = v.raw;
      req_gran        = v.g;
      req_expand_down = v.e;
      req_big         = v.b;
      req_offset      = v.off;
      req_size        = v.sz;
      req_index       = v.idx;
   endtask

   initial begin
      vec_t idle;
      idle = '0;
      rst_n = 1'b0;
      drive(idle, 1'b0);
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 valid", 32'(rsp_valid), 32'd0);
      check("R11 fault", 32'(rsp_fault), 32'd0);
      check("R11 limit", rsp_limit, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 1'b1);
         @(negedge clk);
         check($sformatf("R10 vec%0d valid", i), 32'(rsp_valid), 32'd1);
         check($sformatf("R%0d vec%0d fault", VECS[i].req, i),
               32'(rsp_fault), 32'(VECS[i].flt));
         check($sformatf("R%0d vec%0d limit (R1/R2)", VECS[i].req, i),
               rsp_limit, want_limit(VECS[i].raw, VECS[i].g));
      end

      // R10: idle cycle with changed inputs leaves outputs held (last vec: fault=1, limit=FFF)
      begin
         vec_t chg;
         chg = '{1'b0, 20'h12345, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 13'd0, 1'b0, 4'd10};
         drive(chg, 1'b0);
         @(negedge clk);
         check("R10 idle valid", 32'(rsp_valid), 32'd0);
         check("R10 idle fault held", 32'(rsp_fault), 32'd1);
         check("R10 idle limit held", rsp_limit, 32'h0000_0FFF);
         drive(chg, 1'b1);
         @(negedge clk);
         check("R10 resume valid", 32'(rsp_valid), 32'd1);
         check("R10 resume fault", 32'(rsp_fault), 32'd0);
         check("R1 resume limit", rsp_limit, 32'h0001_2345);
         drive(chg, 1'b0);
      end

      // R11: reset mid-run clears a faulting response
      drive(VECS[1], 1'b1);
      @(negedge clk);
      check("R3 pre-reset fault", 32'(rsp_fault), 32'd1);
      drive(idle, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 mid valid", 32'(rsp_valid), 32'd0);
      check("R11 mid fault", 32'(rsp_fault), 32'd0);
      check("R11 mid limit", rsp_limit, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule